// File: doc/BRIEF.md
# Mode-Banked Integer Register File

This block is the integer register storage of a small 32-bit RISC core. Software always sees sixteen logical registers, but which physical register sits behind a given logical index depends on the operating mode held in the low five bits of the current status word. The fast-interrupt mode has private copies of logical registers 8 through 14. Each of the other four exception modes has private copies of the stack pointer (logical 13) and the link register (logical 14). User and system mode share one bank. Logical 15 is the program counter. In total, 31 general registers, one current status word and five saved status words are held.

The core reads two registers per cycle and writes one. A separate link path lets a branch-with-link deposit its return address into the current mode's link register. On exception entry, a mode-entry request copies the current status into the saved status word of the target mode and switches the mode field. A return request copies the saved status back. Decode, execution and exception vectoring live outside this block.

Top module: `banked_regfile`

## Requirements
- R1: After reset every general register reads zero, the current status reads 0x00000013 (supervisor), and the saved status output reads zero.
- R2: Register writes take effect at the clock edge. A read of the register being written in the same cycle returns the old value, and the new value is visible from the next cycle on. Both read ports behave the same way.
- R3: Logical 15 is one register shared by all modes, and reading it always returns bits 1:0 as zero.
- R4: The mode field is status bits 4:0, coded user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. Logical 0 to 7 are shared by all modes, and logical 8 to 12 are shared by all modes except fast interrupt.
- R5: Fast-interrupt mode has its own copies of logical 8 to 14.
- R6: Interrupt, supervisor, abort and undefined modes each have their own copies of logical 13 and 14.
- R7: System mode uses exactly the same registers as user mode.
- R8: The link path writes logical 14 of the current mode. If the link path and the write port both target logical 14 in the same cycle, the link value is stored.
- R9: A mode-entry request with an exception target stores the current status into that mode's saved status word and replaces status bits 4:0 with the target code, keeping bits 31:5. A target of user or system changes only the mode field. A target code outside the seven legal codes is ignored.
- R10: A return request in an exception mode loads the current status from that mode's saved status word. In user, system or an illegal mode it has no effect.
- R11: The saved status output shows the current mode's saved word. In user, system or an illegal mode it shows the current status.
- R12: While the mode field holds an illegal code, the write port and the link path store nothing, and reads see the user bank.
- R13: When requests coincide, mode entry wins over return, and return wins over a direct status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdAddrA | input | 4 | Logical index, read port A |
| rdDataA | output | 32 | Read data, port A |
| rdAddrB | input | 4 | Logical index, read port B |
| rdDataB | output | 32 | Read data, port B |
| wrEn | input | 1 | Write port enable |
| wrAddr | input | 4 | Write port logical index |
| wrData | input | 32 | Write port data |
| linkWrEn | input | 1 | Link path enable (targets logical 14) |
| linkData | input | 32 | Return address for the link path |
| statusWrEn | input | 1 | Direct load of the current status |
| statusWrData | input | 32 | Value for the direct status load |
| modeEnter | input | 1 | Mode-entry request |
| enterMode | input | 5 | Target mode code for mode entry |
| restoreEn | input | 1 | Return request (saved status to current) |
| curStatus | output | 32 | Current status word |
| savedStatus | output | 32 | Saved status of the current mode |

## Verification
The hardest state to reach is one in which every physical copy holds a distinct value at the same time. Without it, a bank aliasing fault stays invisible. The stimulus walks through all seven modes in a fixed order and writes all sixteen logical indices in each mode with a value that encodes both mode and index. It then reads every index back in every mode. The expected value is the last mode in that order that shares the physical copy. Illegal mode codes and coinciding status requests are reached by loading the status word directly and then issuing the competing requests in a single cycle.

// File: rtl/bank_pkg.sv
`timescale 1ns/1ps
package bank_pkg;
  localparam int MODE_W    = 5;
  localparam int IDX_W     = 4;
  localparam int PHYS_W    = 5;
  localparam int NUM_PHYS  = 31;
  localparam int NUM_SAVED = 5;
  localparam int SLOT_W    = 3;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BK_USR = 3'd0, BK_FIQ = 3'd1, BK_IRQ = 3'd2,
    BK_SVC = 3'd3, BK_ABT = 3'd4, BK_UND = 3'd5
  } bankE;

  typedef struct packed {
    logic               regWe;
    logic [PHYS_W-1:0]  regIdx;
    logic               linkSel;
    logic               saveWe;
    logic [SLOT_W-1:0]  saveSlot;
    logic               enterWe;
    logic [MODE_W-1:0]  newMode;
    logic               restoreWe;
    logic               cpsrLoad;
    bankE               readBank;
    logic [SLOT_W-1:0]  curSlot;
  } ctrlStrobeT;

  function automatic logic modeLegal(input logic [MODE_W-1:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  // user, system and illegal codes all resolve to the shared bank
  function automatic bankE bankOf(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: return BK_FIQ;
      MODE_IRQ: return BK_IRQ;
      MODE_SVC: return BK_SVC;
      MODE_ABT: return BK_ABT;
      MODE_UND: return BK_UND;
      default:  return BK_USR;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] slotOf(input bankE b);
    if (b == BK_USR) return '0;
    return SLOT_W'(int'(b) - 1);
  endfunction

  // physical layout: 0..15 shared, 16..22 fast-interrupt 8..14,
  // then one pair (13,14) per remaining exception bank from 23 upward
  function automatic logic [PHYS_W-1:0] physIndex(input bankE b, input logic [IDX_W-1:0] r);
    int v;
    v = int'(r);
    if (r == 4'd15 || r < 4'd8) v = int'(r);
    else if (b == BK_FIQ) v = int'(r) + 8;
    else if (r >= 4'd13 && b != BK_USR) v = 23 + 2 * (int'(b) - 2) + (int'(r) - 13);
    return PHYS_W'(v);
  endfunction
endpackage

// File: rtl/bank_ctrl.sv
`timescale 1ns/1ps
module bank_ctrl
  import bank_pkg::*;
(
  input  logic [MODE_W-1:0] curMode,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic              linkWrEn,
  input  logic              statusWrEn,
  input  logic              modeEnter,
  input  logic [MODE_W-1:0] enterMode,
  input  logic              restoreEn,
  output ctrlStrobeT        strobe
);
  bankE curBank;
  bankE tgtBank;
  logic curLegal;
  logic enterOk;
  logic restoreOk;
  logic [IDX_W-1:0] tgtAddr;

  always_comb begin
    curBank   = bankOf(curMode);
    tgtBank   = bankOf(enterMode);
    curLegal  = modeLegal(curMode);
    enterOk   = modeEnter && modeLegal(enterMode);
    restoreOk = !enterOk && restoreEn && (curBank != BK_USR);
    tgtAddr   = linkWrEn ? 4'd14 : wrAddr;

    strobe           = '0;
    strobe.regWe     = curLegal && (wrEn || linkWrEn);
    strobe.regIdx    = physIndex(curBank, tgtAddr);
    strobe.linkSel   = linkWrEn;
    strobe.enterWe   = enterOk;
    strobe.newMode   = enterMode;
    strobe.saveWe    = enterOk && (tgtBank != BK_USR);
    strobe.saveSlot  = slotOf(tgtBank);
    strobe.restoreWe = restoreOk;
    strobe.cpsrLoad  = !enterOk && !restoreOk && statusWrEn;
    strobe.readBank  = curBank;
    strobe.curSlot   = slotOf(curBank);
  end
endmodule

// File: rtl/bank_store.sv
`timescale 1ns/1ps
module bank_store
  import bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [IDX_W-1:0]  rdAddrA,
  input  logic [IDX_W-1:0]  rdAddrB,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] linkData,
  input  logic [DATA_W-1:0] statusWrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] cpsr,
  output logic [DATA_W-1:0] savedStatus
);
  localparam logic [DATA_W-1:0] PC_MASK   = ~DATA_W'(3);
  localparam logic [DATA_W-1:0] CPSR_INIT = DATA_W'(MODE_SVC);

  logic [DATA_W-1:0] physReg  [NUM_PHYS];
  logic [DATA_W-1:0] savedReg [NUM_SAVED];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PHYS; i++) physReg[i] <= '0;
    end else if (strobe.regWe) begin
      physReg[strobe.regIdx] <= strobe.linkSel ? linkData : wrData;
    end
  end

  for (genvar s = 0; s < NUM_SAVED; s++) begin : g_saved
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) savedReg[s] <= '0;
      else if (strobe.saveWe && strobe.saveSlot == SLOT_W'(s)) savedReg[s] <= cpsr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cpsr <= CPSR_INIT;
    else if (strobe.enterWe)   cpsr <= {cpsr[DATA_W-1:MODE_W], strobe.newMode};
    else if (strobe.restoreWe) cpsr <= savedReg[strobe.curSlot];
    else if (strobe.cpsrLoad)  cpsr <= statusWrData;
  end

  function automatic logic [DATA_W-1:0] readPort(input logic [IDX_W-1:0] r);
    logic [DATA_W-1:0] v;
    v = physReg[physIndex(strobe.readBank, r)];
    return (r == 4'd15) ? (v & PC_MASK) : v;
  endfunction

  always_comb begin
    rdDataA     = readPort(rdAddrA);
    rdDataB     = readPort(rdAddrB);
    savedStatus = (strobe.readBank == BK_USR) ? cpsr : savedReg[strobe.curSlot];
  end
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile
  import bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              linkWrEn,
  input  logic [DATA_W-1:0] linkData,
  input  logic              statusWrEn,
  input  logic [DATA_W-1:0] statusWrData,
  input  logic              modeEnter,
  input  logic [4:0]        enterMode,
  input  logic              restoreEn,
  output logic [DATA_W-1:0] curStatus,
  output logic [DATA_W-1:0] savedStatus
);
  ctrlStrobeT strobe;

  bank_ctrl u_ctrl (
    .curMode    (curStatus[MODE_W-1:0]),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .linkWrEn   (linkWrEn),
    .statusWrEn (statusWrEn),
    .modeEnter  (modeEnter),
    .enterMode  (enterMode),
    .restoreEn  (restoreEn),
    .strobe     (strobe)
  );

  bank_store #(.DATA_W(DATA_W)) u_store (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .rdAddrA      (rdAddrA),
    .rdAddrB      (rdAddrB),
    .wrData       (wrData),
    .linkData     (linkData),
    .statusWrData (statusWrData),
    .rdDataA      (rdDataA),
    .rdDataB      (rdDataB),
    .cpsr         (curStatus),
    .savedStatus  (savedStatus)
  );
endmodule

// File: rtl/banked_regfile_chk.sv
`timescale 1ns/1ps
module banked_regfile_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [DATA_W-1:0] curStatus,
  input logic [DATA_W-1:0] savedStatus,
  input logic              modeEnter,
  input logic [4:0]        enterMode,
  input logic              restoreEn,
  input logic              statusWrEn,
  input logic [DATA_W-1:0] statusWrData
);
  function automatic logic isExc(input logic [4:0] m);
    return m == 5'b10001 || m == 5'b10010 || m == 5'b10011 ||
           m == 5'b10111 || m == 5'b11011;
  endfunction

  logic curExc;
  assign curExc = isExc(curStatus[4:0]);

  assert_pc_low_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == 4'd15) |-> (rdDataA[1:0] == 2'b00));

  assert_saved_mirrors_R11: assert property (@(posedge clk) disable iff (!rstN)
    !curExc |-> (savedStatus == curStatus));

  assert_enter_saves_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeEnter && isExc(enterMode)) |=>
      (curStatus[4:0] == $past(enterMode) && savedStatus == $past(curStatus)));

  assert_restore_loads_R10: assert property (@(posedge clk) disable iff (!rstN)
    (restoreEn && !modeEnter && curExc) |=> (curStatus == $past(savedStatus)));

  assert_status_priority_R13: assert property (@(posedge clk) disable iff (!rstN)
    (statusWrEn && !modeEnter && !(restoreEn && curExc)) |=>
      (curStatus == $past(statusWrData)));
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .rdAddrA      (rdAddrA),
  .rdDataA      (rdDataA),
  .curStatus    (curStatus),
  .savedStatus  (savedStatus),
  .modeEnter    (modeEnter),
  .enterMode    (enterMode),
  .restoreEn    (restoreEn),
  .statusWrEn   (statusWrEn),
  .statusWrData (statusWrData)
);

// File: tb/tb_banked_regfile.sv
`timescale 1ns/1ps
module tb_banked_regfile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0, linkData = '0, statusWrData = '0;
  logic        wrEn = 0, linkWrEn = 0, statusWrEn = 0, modeEnter = 0, restoreEn = 0;
  logic [4:0]  enterMode = '0;
  logic [31:0] curStatus, savedStatus;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                         M_SYS = 5'b11111;
  localparam logic [4:0] MODES [7] = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS};

  banked_regfile dut (.*);

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic idle();
    wrEn = 0; linkWrEn = 0; statusWrEn = 0; modeEnter = 0; restoreEn = 0;
  endtask

  task automatic setStatus(input logic [31:0] v);
    statusWrEn = 1; statusWrData = v; step(); idle();
  endtask

  task automatic writeReg(input logic [3:0] r, input logic [31:0] v);
    wrEn = 1; wrAddr = r; wrData = v; step(); idle();
  endtask

  function automatic logic [31:0] pat(input logic [4:0] m, input int r);
    return 32'h5A00_0003 | (32'(m) << 16) | (32'(r) << 4);
  endfunction

  // last mode in the sweep order that shares the physical copy (R4..R7)
  function automatic logic [4:0] lastWriter(input logic [4:0] m, input int r);
    if (m == M_FIQ && r >= 8 && r <= 14) return M_FIQ;
    if ((m == M_IRQ || m == M_SVC || m == M_ABT || m == M_UND) && r >= 13 && r <= 14) return m;
    return M_SYS;
  endfunction

  function automatic logic [31:0] expRead(input logic [4:0] m, input int r);
    logic [31:0] v;
    v = pat(lastWriter(m, r), r);
    return (r == 15) ? (v & ~32'd3) : v;
  endfunction

  initial begin
    #4_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    step();

    // R1: reset state
    check("R1 status", curStatus, 32'h0000_0013);
    check("R1 saved", savedStatus, 32'h0);
    for (int r = 0; r < 16; r++) begin
      rdAddrA = 4'(r); #1;
      check("R1 reg", rdDataA, 32'h0);
    end

    // R4..R7: write every index in every mode
    for (int mi = 0; mi < 7; mi++) begin
      setStatus({27'b0, MODES[mi]});
      for (int r = 0; r < 16; r++) writeReg(4'(r), pat(MODES[mi], r));
    end
    // read all indices back in every mode, both ports (R3, R4, R5, R6, R7)
    for (int mi = 0; mi < 7; mi++) begin
      setStatus({27'b0, MODES[mi]});
      for (int r = 0; r < 16; r++) begin
        rdAddrA = 4'(r); rdAddrB = 4'(15 - r); #1;
        check("R4/R5/R6/R7 bank portA", rdDataA, expRead(MODES[mi], r));
        check("R3/R4 bank portB", rdDataB, expRead(MODES[mi], 15 - r));
      end
    end

    // R2: read during write returns old value, new value next cycle
    setStatus({27'b0, M_USR});
    wrEn = 1; wrAddr = 4'd3; wrData = 32'hDEAD_BEEF; rdAddrA = 4'd3; rdAddrB = 4'd3; #1;
    check("R2 old A", rdDataA, pat(M_SYS, 3));
    check("R2 old B", rdDataB, pat(M_SYS, 3));
    step(); idle();
    check("R2 new A", rdDataA, 32'hDEAD_BEEF);
    check("R2 new B", rdDataB, 32'hDEAD_BEEF);

    // R3: program counter low bits read as zero, shared across modes
    writeReg(4'd15, 32'h1234_5677);
    setStatus({27'b0, M_FIQ});
    rdAddrA = 4'd15; #1;
    check("R3 pc mask", rdDataA, 32'h1234_5674);

    // R8: link path wins over write port to R14; lands in current bank
    setStatus({27'b0, M_IRQ});
    wrEn = 1; wrAddr = 4'd14; wrData = 32'h1111_1111;
    linkWrEn = 1; linkData = 32'h2222_2222;
    step(); idle();
    rdAddrA = 4'd14; #1;
    check("R8 link priority", rdDataA, 32'h2222_2222);
    setStatus({27'b0, M_USR});
    linkWrEn = 1; linkData = 32'h3333_3333; step(); idle();
    setStatus({27'b0, M_SYS});
    rdAddrA = 4'd14; #1;
    check("R8 link user bank via sys", rdDataA, 32'h3333_3333);
    setStatus({27'b0, M_SVC});
    rdAddrA = 4'd14; #1;
    check("R8 svc link untouched", rdDataA, pat(M_SVC, 14));

    // R9: mode entry saves status and switches mode
    setStatus(32'hF000_0010);
    modeEnter = 1; enterMode = M_IRQ; step(); idle();
    check("R9 enter status", curStatus, 32'hF000_0012);
    check("R9 enter saved", savedStatus, 32'hF000_0010);
    modeEnter = 1; enterMode = 5'b10100; step(); idle();
    check("R9 illegal target ignored", curStatus, 32'hF000_0012);

    // R10: return restores saved status
    setStatus(32'h2000_0012);
    restoreEn = 1; step(); idle();
    check("R10 restore", curStatus, 32'hF000_0010);
    restoreEn = 1; step(); idle();
    check("R10 restore in user no effect", curStatus, 32'hF000_0010);

    // R9/R11: entering system changes mode only, saved mirrors current
    modeEnter = 1; enterMode = M_SYS; step(); idle();
    check("R9 enter sys", curStatus, 32'hF000_001F);
    check("R11 saved mirrors in sys", savedStatus, 32'hF000_001F);

    // R13: entry beats return beats status write
    modeEnter = 1; enterMode = M_SVC; restoreEn = 1;
    statusWrEn = 1; statusWrData = 32'h0000_001B;
    step(); idle();
    check("R13 entry wins", curStatus, 32'hF000_0013);
    check("R13 entry saved", savedStatus, 32'hF000_001F);
    restoreEn = 1; statusWrEn = 1; statusWrData = 32'h0000_0010;
    step(); idle();
    check("R13 return beats status write", curStatus, 32'hF000_001F);

    // R12: illegal mode blocks writes, reads see user bank
    setStatus(32'h0000_0014);
    writeReg(4'd0, 32'hBAD0_BAD0);
    linkWrEn = 1; linkData = 32'hBAD1_BAD1; step(); idle();
    rdAddrA = 4'd0; rdAddrB = 4'd14; #1;
    check("R12 write ignored", rdDataA, pat(M_SYS, 0));
    check("R12 link ignored, user bank", rdDataB, 32'h3333_3333);
    check("R11 saved mirrors in illegal", savedStatus, 32'h0000_0014);
    setStatus({27'b0, M_USR});
    rdAddrA = 4'd0; rdAddrB = 4'd14; #1;
    check("R12 user R0 intact", rdDataA, pat(M_SYS, 0));
    check("R12 user R14 intact", rdDataB, 32'h3333_3333);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule